// File: doc/BRIEF.md
# Perpendicular Recording Mode Controller

This block keeps the perpendicular-recording settings of a floppy disk controller and turns them into write-format parameters for whichever drive an operation targets. A command write loads two global mode bits (a gate-enable bit and a wide-gap bit), an overwrite-enable bit, and one perpendicular flag per drive. A query port takes a drive number and the current data rate. From these it returns, in the same cycle:

- the effective recording mode,
- the GAP2 length to format,
- how many GAP2 bytes a write-data operation rewrites,
- whether write precompensation applies.

Two reset pulses exist. A soft reset clears only the global bits. A hard reset clears all stored state. When either global bit is set, it overrides the per-drive flags for every drive. When both are clear, each drive's own flag decides its mode, and a flagged drive picks its gap size from the data rate.

Top module: `perp_mode_ctrl`

## Requirements
- R1: With both global bits 0 and the queried drive's flag 0, the mode output is 00 (conventional), the GAP2 length is 22 and the rewritten count is 0.
- R2: With the gate-enable bit 1 and the wide-gap bit 0, every drive reports mode 01 (perpendicular, short gap), length 22 and rewrite 19, whatever its flag and the data rate.
- R3: With the gate-enable bit 0 and the wide-gap bit 1, every drive reports mode 00, length 22 and rewrite 0, whatever its flag.
- R4: With both global bits 1, every drive reports mode 10 (perpendicular, long gap), length 41 and rewrite 38, whatever its flag and the data rate.
- R5: With both global bits 0 and the queried drive's flag 1, a data rate of 2'b11 (1 Mbps) gives mode 10 with 41/38. Any other rate (00=500K, 01=300K, 10=250K) gives mode 01 with 22/19.
- R6: A command write always loads both global bits. It replaces the four drive flags (bit n = drive n) only when its overwrite bit is 1; otherwise the old flags stay.
- R7: A soft reset clears both global bits and leaves the drive flags unchanged.
- R8: A hard reset clears both global bits and all drive flags.
- R9: A reset in the same cycle as a command write wins, and no part of the write is stored. A hard reset takes precedence over a soft reset.
- R10: The precompensation-enable output is 1 exactly when the reported mode is conventional.
- R11: Query outputs respond to the query inputs without a clock edge. A command write or reset becomes visible after the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| hwReset | input | 1 | Synchronous hard reset pulse, clears all state |
| swReset | input | 1 | Synchronous soft reset pulse, clears the global bits |
| cmdWrite | input | 1 | Command write strobe |
| cmdGateEn | input | 1 | Global gate-enable bit of the command |
| cmdWideGap | input | 1 | Global wide-gap bit of the command |
| cmdOverwrite | input | 1 | Allows the drive flags of this command to be stored |
| cmdDriveFlags | input | 4 | Per-drive perpendicular flags, bit n for drive n |
| qDrive | input | 2 | Drive number of the query |
| qRate | input | 2 | Data rate: 00=500K, 01=300K, 10=250K, 11=1M |
| modeOut | output | 2 | 00 conventional, 01 perpendicular short gap, 10 perpendicular long gap |
| gap2Len | output | 6 | GAP2 length in bytes |
| gap2Rewrite | output | 6 | GAP2 bytes rewritten by write data |
| precompOn | output | 1 | Write precompensation applies |

## Verification
The bench targets the corners a wrong design would blur. A write with overwrite 0 must leave the flags alone, or a later per-drive query shows the wrong mode. A soft reset must keep the flags, or a flagged drive drops back to conventional. A reset that collides with a write must not let the write slip through, or the stale global bits then override the drives. The reserved 01 global code must stay conventional rather than being taken as perpendicular. A flagged drive must select the long gap only at 1 Mbps, or the other rates report 41/38 instead of 22/19.

// File: rtl/perp_mode_pkg.sv
package perp_mode_pkg;

  typedef enum logic [1:0] {
    MODE_CONV       = 2'b00,
    MODE_PERP_SHORT = 2'b01,
    MODE_PERP_LONG  = 2'b10
  } perp_mode_e;

  typedef struct packed {
    logic loadGlobal;
    logic loadFlags;
    logic clearGlobal;
    logic clearFlags;
  } reg_strobe_t;

  localparam logic [1:0] RATE_FAST = 2'b11;

endpackage

// File: rtl/perp_mode_ctl.sv
module perp_mode_ctl
  import perp_mode_pkg::*;
(
  input  logic        hwReset,
  input  logic        swReset,
  input  logic        cmdWrite,
  input  logic        cmdOverwrite,
  output reg_strobe_t strobe
);

  always_comb begin
    strobe = '0;
    if (hwReset) begin
      strobe.clearGlobal = 1'b1;
      strobe.clearFlags  = 1'b1;
    end else if (swReset) begin
      strobe.clearGlobal = 1'b1;
    end else if (cmdWrite) begin
      strobe.loadGlobal = 1'b1;
      strobe.loadFlags  = cmdOverwrite;
    end
  end

endmodule

// File: rtl/perp_mode_dp.sv
module perp_mode_dp
  import perp_mode_pkg::*;
#(
  parameter int NUM_DRIVES    = 4,
  parameter int GAP_W         = 6,
  parameter int SHORT_GAP     = 22,
  parameter int LONG_GAP      = 41,
  parameter int SHORT_REWRITE = 19,
  parameter int LONG_REWRITE  = 38,
  localparam int SEL_W        = (NUM_DRIVES > 1) ? $clog2(NUM_DRIVES) : 1
) (
  input  logic                  clk,
  input  logic                  hwReset,
  input  reg_strobe_t           strobe,
  input  logic                  cmdGateEn,
  input  logic                  cmdWideGap,
  input  logic [NUM_DRIVES-1:0] cmdDriveFlags,
  input  logic [SEL_W-1:0]      qDrive,
  input  logic [1:0]            qRate,
  output perp_mode_e            modeOut,
  output logic [GAP_W-1:0]      gap2Len,
  output logic [GAP_W-1:0]      gap2Rewrite,
  output logic                  precompOn
);

  logic                  gateEnQ;
  logic                  wideGapQ;
  logic [NUM_DRIVES-1:0] driveFlagsQ;

  always_ff @(posedge clk) begin
    if (strobe.clearGlobal) begin
      gateEnQ  <= 1'b0;
      wideGapQ <= 1'b0;
    end else if (strobe.loadGlobal) begin
      gateEnQ  <= cmdGateEn;
      wideGapQ <= cmdWideGap;
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.clearFlags)
      driveFlagsQ <= '0;
    else if (strobe.loadFlags)
      driveFlagsQ <= cmdDriveFlags;
  end

  // Per-drive flag selection.
  logic [NUM_DRIVES-1:0] driveHit;
  generate
    for (genvar d = 0; d < NUM_DRIVES; d++) begin : g_sel
      assign driveHit[d] = (qDrive == SEL_W'(d)) && driveFlagsQ[d];
    end
  endgenerate
  logic selFlag;
  assign selFlag = |driveHit;

  always_comb begin
    unique case ({gateEnQ, wideGapQ})
      2'b10:   modeOut = MODE_PERP_SHORT;
      2'b01:   modeOut = MODE_CONV;
      2'b11:   modeOut = MODE_PERP_LONG;
      default: begin
        if (!selFlag)                modeOut = MODE_CONV;
        else if (qRate == RATE_FAST) modeOut = MODE_PERP_LONG;
        else                         modeOut = MODE_PERP_SHORT;
      end
    endcase
  end

  always_comb begin
    case (modeOut)
      MODE_PERP_SHORT: begin
        gap2Len     = GAP_W'(SHORT_GAP);
        gap2Rewrite = GAP_W'(SHORT_REWRITE);
      end
      MODE_PERP_LONG: begin
        gap2Len     = GAP_W'(LONG_GAP);
        gap2Rewrite = GAP_W'(LONG_REWRITE);
      end
      default: begin
        gap2Len     = GAP_W'(SHORT_GAP);
        gap2Rewrite = '0;
      end
    endcase
  end

  assign precompOn = (modeOut == MODE_CONV);

  // Assertions.
  assert_sw_keeps_flags_R7: assert property (@(posedge clk) disable iff (hwReset)
    (strobe.clearGlobal && !strobe.clearFlags) |=>
      (!gateEnQ && !wideGapQ && $stable(driveFlagsQ)));

  assert_hw_clears_R8: assert property (@(posedge clk)
    $fell(hwReset) |-> (!gateEnQ && !wideGapQ && driveFlagsQ == '0));

  assert_no_overwrite_R6: assert property (@(posedge clk) disable iff (hwReset)
    (strobe.loadGlobal && !strobe.loadFlags) |=> $stable(driveFlagsQ));

  assert_overwrite_R6: assert property (@(posedge clk) disable iff (hwReset)
    strobe.loadFlags |=> (driveFlagsQ == $past(cmdDriveFlags)));

  assert_conv_gap_R1: assert property (@(posedge clk) disable iff (hwReset)
    precompOn |-> (gap2Rewrite == '0 && gap2Len == GAP_W'(SHORT_GAP)));

  assert_perp_precomp_R10: assert property (@(posedge clk) disable iff (hwReset)
    (gap2Rewrite != '0) |-> !precompOn);

  assert_global_long_R4: assert property (@(posedge clk) disable iff (hwReset)
    (gateEnQ && wideGapQ) |-> (gap2Len == GAP_W'(LONG_GAP)));

endmodule

// File: rtl/perp_mode_ctrl.sv
module perp_mode_ctrl
  import perp_mode_pkg::*;
(
  input  logic       clk,
  input  logic       hwReset,
  input  logic       swReset,
  input  logic       cmdWrite,
  input  logic       cmdGateEn,
  input  logic       cmdWideGap,
  input  logic       cmdOverwrite,
  input  logic [3:0] cmdDriveFlags,
  input  logic [1:0] qDrive,
  input  logic [1:0] qRate,
  output logic [1:0] modeOut,
  output logic [5:0] gap2Len,
  output logic [5:0] gap2Rewrite,
  output logic       precompOn
);

  reg_strobe_t strobe;
  perp_mode_e  modeInt;

  perp_mode_ctl u_ctl (
    .hwReset      (hwReset),
    .swReset      (swReset),
    .cmdWrite     (cmdWrite),
    .cmdOverwrite (cmdOverwrite),
    .strobe       (strobe)
  );

  perp_mode_dp #(.NUM_DRIVES(4), .GAP_W(6)) u_dp (
    .clk           (clk),
    .hwReset       (hwReset),
    .strobe        (strobe),
    .cmdGateEn     (cmdGateEn),
    .cmdWideGap    (cmdWideGap),
    .cmdDriveFlags (cmdDriveFlags),
    .qDrive        (qDrive),
    .qRate         (qRate),
    .modeOut       (modeInt),
    .gap2Len       (gap2Len),
    .gap2Rewrite   (gap2Rewrite),
    .precompOn     (precompOn)
  );

  assign modeOut = modeInt;

  assert_hw_over_sw_R9: assert property (@(posedge clk)
    (hwReset && swReset) |-> strobe.clearFlags);

  assert_reset_beats_write_R9: assert property (@(posedge clk)
    ((hwReset || swReset) && cmdWrite) |-> (!strobe.loadGlobal && !strobe.loadFlags));

endmodule

// File: tb/sim_perp_mode_ctrl.sv
`timescale 1ns/100ps
module sim_perp_mode_ctrl;

  logic       clk = 1'b0;
  logic       hwReset = 1'b1;
  logic       swReset = 1'b0;
  logic       cmdWrite = 1'b0;
  logic       cmdGateEn = 1'b0;
  logic       cmdWideGap = 1'b0;
  logic       cmdOverwrite = 1'b0;
  logic [3:0] cmdDriveFlags = '0;
  logic [1:0] qDrive = '0;
  logic [1:0] qRate = '0;
  logic [1:0] modeOut;
  logic [5:0] gap2Len;
  logic [5:0] gap2Rewrite;
  logic       precompOn;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // Bench model of stored state
  logic [1:0] mGlob;   // {gateEn, wideGap}
  logic [3:0] mFlags;

  always #2.5 clk = ~clk;

  perp_mode_ctrl u0 (
    .clk(clk), .hwReset(hwReset), .swReset(swReset), .cmdWrite(cmdWrite),
    .cmdGateEn(cmdGateEn), .cmdWideGap(cmdWideGap), .cmdOverwrite(cmdOverwrite),
    .cmdDriveFlags(cmdDriveFlags), .qDrive(qDrive), .qRate(qRate),
    .modeOut(modeOut), .gap2Len(gap2Len), .gap2Rewrite(gap2Rewrite),
    .precompOn(precompOn)
  );

  function automatic logic [1:0] expMode(input logic [1:0] d, input logic [1:0] r);
    case (mGlob)
      2'b10: return 2'b01;
      2'b01: return 2'b00;
      2'b11: return 2'b10;
      default: begin
        if (!mFlags[d]) return 2'b00;
        return (r == 2'b11) ? 2'b10 : 2'b01;
      end
    endcase
  endfunction

  function automatic string tagFor(input logic [1:0] d);
    case (mGlob)
      2'b10: return "R2";
      2'b01: return "R3";
      2'b11: return "R4";
      default: return mFlags[d] ? "R5" : "R1";
    endcase
  endfunction

  task automatic check(input string tag, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // Query outputs settle without a clock edge (R11)
  task automatic query(input logic [1:0] d, input logic [1:0] r, input string ctx);
    logic [1:0] m;
    int len, rw;
    qDrive = d; qRate = r;
    #0.5;
    m   = expMode(d, r);
    len = (m == 2'b10) ? 41 : 22;
    rw  = (m == 2'b10) ? 38 : (m == 2'b01) ? 19 : 0;
    check({tagFor(d), "/", ctx}, modeOut, m, $sformatf("mode d%0d r%0d", d, r));
    check({tagFor(d), "/", ctx}, gap2Len, len, "gap2Len");
    check({tagFor(d), "/", ctx}, gap2Rewrite, rw, "gap2Rewrite");
    check({"R10/", ctx}, precompOn, (m == 2'b00), "precompOn");
  endtask

  task automatic queryAll(input string ctx);
    for (int d = 0; d < 4; d++)
      for (int r = 0; r < 4; r++)
        query(2'(d), 2'(r), ctx);
  endtask

  // One clocked cycle: inputs applied at negedge, model updated after the edge
  task automatic cycle(input bit hw, input bit sw, input bit wr, input bit ge,
                       input bit wg, input bit ow, input logic [3:0] fl);
    @(negedge clk);
    hwReset = hw; swReset = sw; cmdWrite = wr;
    cmdGateEn = ge; cmdWideGap = wg; cmdOverwrite = ow; cmdDriveFlags = fl;
    @(posedge clk);
    if (hw) begin mGlob = 2'b00; mFlags = 4'b0000; end
    else if (sw) mGlob = 2'b00;
    else if (wr) begin
      mGlob = {ge, wg};
      if (ow) mFlags = fl;
    end
    #1;
    hwReset = 1'b0; swReset = 1'b0; cmdWrite = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    mGlob = 2'b00; mFlags = 4'b0000;
    cycle(1, 0, 0, 0, 0, 0, 4'h0);
    cycle(1, 0, 0, 0, 0, 0, 4'h0);
    queryAll("R8 reset state");

    // R6: write with overwrite loads flags; R2 overrides them
    cycle(0, 0, 1, 1, 0, 1, 4'b1010);
    queryAll("R6 load, R2 global");
    // R7: soft reset keeps flags -> per-drive R5 shows through
    cycle(0, 1, 0, 0, 0, 0, 4'h0);
    queryAll("R7 soft reset");
    // R6: write without overwrite keeps flags
    cycle(0, 0, 1, 0, 0, 0, 4'b0101);
    queryAll("R6 no overwrite");
    // R3 reserved code
    cycle(0, 0, 1, 0, 1, 0, 4'h0);
    queryAll("R3 reserved");
    // R4 long gap global
    cycle(0, 0, 1, 1, 1, 1, 4'b0001);
    queryAll("R4 global long");
    // R9: soft reset with write -> write dropped
    cycle(0, 1, 1, 1, 1, 1, 4'b1111);
    queryAll("R9 sw vs write");
    // R9: hard over soft
    cycle(1, 1, 1, 1, 0, 1, 4'b1111);
    queryAll("R9 hw vs sw");
    // R8 after flags set
    cycle(0, 0, 1, 0, 0, 1, 4'b1111);
    cycle(1, 0, 0, 0, 0, 0, 4'h0);
    queryAll("R8 hard reset");

    // Constrained random mix
    for (int i = 0; i < 400; i++) begin
      int sel = $urandom_range(0, 19);
      bit hw = (sel == 0);
      bit sw = (sel <= 3) && (sel != 0);
      bit wr = (sel >= 2);
      cycle(hw, sw, wr, 1'($urandom), 1'($urandom), 1'($urandom), 4'($urandom));
      for (int k = 0; k < 3; k++)
        query(2'($urandom), 2'($urandom), "R11 random");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule